// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Sequential Stream Buffer

This block is a read-only, direct-mapped data cache. A small two-line stream buffer sits beside the main array. A processor presents a byte address with a valid/ready handshake. The block answers with the 32-bit word that holds that address and a flag that says whether the access hit. Lines come from memory through a single-outstanding line request port. The memory can answer after any number of cycles.

Every line that enters the main array starts a sequential prefetch. With prefetching enabled, a demand fill of line L queues L+1 and L+2 into the stream buffer. A lookup that misses the array but finds its line in the buffer counts as a hit. The line is then copied into its array slot, and the freed buffer entry is refilled with the next line beyond the buffer's contents. If a lookup matches a buffer entry whose fill is still on its way, the lookup waits for that fill and also counts as a hit.

A demand miss that also misses the buffer throws the buffer away and restarts the prefetch stream behind the missing line. Two counters give the number of hits and misses, so the miss rate of an address stream can be measured.

Top module: `stream_prefetch_cache`

## Requirements
- R1: A synchronous active-high `rst` invalidates every array line and buffer entry and zeroes both counters. After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: Address bits [4:0] are the byte offset, [15:5] the line index and [31:16] the tag. The returned word is word number addr[4:2] of the line. Two addresses with the same index and different tags evict each other.
- R3: A lookup that hits the main array returns `rsp_hit`=1 two clock edges after acceptance and issues no memory request.
- R4: A lookup that misses both the array and the buffer requests its line on `mem_req_addr`, a byte address with bits [4:0] zero. It answers with `rsp_hit`=0 only after that line has returned.
- R5: With `prefetch_en`=1, a demand fill of line L is followed by memory requests for L+1 and then L+2.
- R6: A lookup that finds a ready line in the buffer answers with `rsp_hit`=1 and counts as a hit. The line is written into the main array, so later lookups to it need no memory request.
- R7: Each buffer line consumed queues the next line beyond the buffer's contents. A sequential stream therefore sees memory requests that rise by exactly one line each.
- R8: A lookup whose line is in a buffer entry still being fetched waits for that fill and answers with `rsp_hit`=1.
- R9: A demand miss that also misses the buffer flushes the buffer and restarts prefetching at the miss line plus one. A response to a flushed prefetch is discarded.
- R10: At most one memory request is outstanding. A waiting demand fetch is issued before any queued prefetch.
- R11: With `prefetch_en`=0, no new prefetch is queued. A stream with a 2-byte stride then misses once per 16 accesses.
- R12: `hit_count` rises by one with each response that has `rsp_hit`=1. `miss_count` rises by one with each response that has `rsp_hit`=0.
- R13: With `prefetch_en`=1, a 2-byte stride stream over 16 consecutive lines misses only on its first access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prefetch_en | input | 1 | Allows new prefetches to be queued |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_addr | input | 32 | Byte address of the lookup |
| rsp_valid | output | 1 | One-cycle pulse carrying a result |
| rsp_hit | output | 1 | Result came from the array or the buffer |
| rsp_data | output | 32 | Word containing the requested address |
| mem_req_valid | output | 1 | Line request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the requested line |
| mem_rsp_valid | input | 1 | One-cycle pulse carrying a line |
| mem_rsp_data | input | 256 | Line contents, word 0 in the low bits |
| hit_count | output | 32 | Number of hit responses |
| miss_count | output | 32 | Number of miss responses |

## Verification
The bench first runs a 2-byte stride stream with prefetching off. This gives the baseline of one miss per line, and the memory requests must rise by one line each. The same kind of stream with prefetching on separates buffer hits from misses and checks the request sequence L, L+1, L+2, and so on. A pair of addresses with the same index and different tags exposes eviction and word selection. A slow memory with back-to-back requests tells a stall on an in-flight entry apart from a real miss. It also shows whether a jump to a far address throws away the prefetch that was still on its way.

// File: rtl/stream_prefetch_cache.sv
module stream_prefetch_cache #(
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 2048,
  parameter int CNT_W      = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    prefetch_en,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [31:0]             req_addr,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic [31:0]             rsp_data,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [31:0]             mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [LINE_BYTES*8-1:0] mem_rsp_data,
  output logic [CNT_W-1:0]        hit_count,
  output logic [CNT_W-1:0]        miss_count
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = 32 - OFF_W - IDX_W;
  localparam int LA_W   = 32 - OFF_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WS_W   = OFF_W - 2;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_DREQ, S_DWAIT} state_t;
  typedef enum logic [1:0] {E_EMPTY, E_QUEUED, E_FLIGHT, E_FULL} ent_t;

  state_t               state;
  logic [31:2]          addr_q;
  logic [NUM_LINES-1:0] vld;
  logic [TAG_W-1:0]     tag_mem  [NUM_LINES];
  logic [LINE_W-1:0]    data_mem [NUM_LINES];
  ent_t                 sb_st    [2];
  logic [LA_W-1:0]      sb_line  [2];
  logic [LINE_W-1:0]    sb_data  [2];
  logic [LA_W-1:0]      pf_next;
  logic                 mem_busy, mem_own, mem_ent, mem_drop;
  logic [1:0]           sb_match, sb_ready, sb_q;

  wire [LA_W-1:0]  line_q = addr_q[31:OFF_W];
  wire [IDX_W-1:0] idx    = addr_q[OFF_W +: IDX_W];
  wire [TAG_W-1:0] tag    = addr_q[31 -: TAG_W];
  wire [WS_W-1:0]  wsel   = addr_q[OFF_W-1:2];
  wire             c_hit  = vld[idx] && (tag_mem[idx] == tag);

  for (genvar e = 0; e < 2; e++) begin : g_sb
    assign sb_match[e] = (sb_st[e] != E_EMPTY) && (sb_line[e] == line_q);
    assign sb_ready[e] = sb_match[e] && (sb_st[e] == E_FULL);
    assign sb_q[e]     = (sb_st[e] == E_QUEUED);
  end

  wire b_hit   = |sb_ready;
  wire b_e     = sb_ready[1];
  wire b_wait  = |(sb_match & ~sb_ready);
  wire pf_e    = !sb_q[0];
  wire demand  = (state == S_DREQ);

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = !mem_busy && (demand || |sb_q);
  assign mem_req_addr  = {demand ? line_q : sb_line[pf_e], {OFF_W{1'b0}}};

  wire fire    = mem_req_valid && mem_req_ready;
  wire pf_fire = fire && !demand;
  wire fill    = (state == S_DWAIT) && mem_rsp_valid && !mem_own;
  wire promote = (state == S_LOOK) && !c_hit && b_hit;

  wire [LINE_W-1:0] new_line = fill ? mem_rsp_data : sb_data[b_e];
  wire [LINE_W-1:0] cur_line = data_mem[idx];
  wire [31:0]       new_word = new_line[{wsel, 5'd0} +: 32];
  wire [31:0]       cur_word = cur_line[{wsel, 5'd0} +: 32];

  always_ff @(posedge clk) begin
    if (fill || promote) begin
      data_mem[idx] <= new_line;
      tag_mem[idx]  <= tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      addr_q     <= '0;
      vld        <= '0;
      sb_st[0]   <= E_EMPTY;
      sb_st[1]   <= E_EMPTY;
      pf_next    <= '0;
      mem_busy   <= 1'b0;
      mem_own    <= 1'b0;
      mem_ent    <= 1'b0;
      mem_drop   <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_data   <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (fill || promote) vld[idx] <= 1'b1;

      if (fire) begin
        mem_busy <= 1'b1;
        mem_own  <= !demand;
        mem_ent  <= pf_e;
        if (!demand) sb_st[pf_e] <= E_FLIGHT;
      end
      if (mem_rsp_valid) begin
        mem_busy <= 1'b0;
        mem_drop <= 1'b0;
        if (mem_own && !mem_drop) begin
          sb_st[mem_ent]   <= E_FULL;
          sb_data[mem_ent] <= mem_rsp_data;
        end
      end

      case (state)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr[31:2];
          state  <= S_LOOK;
        end
        S_LOOK: begin
          if (c_hit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_data  <= cur_word;
            hit_count <= hit_count + CNT_W'(1);
            state     <= S_IDLE;
          end else if (b_hit) begin
            rsp_valid     <= 1'b1;
            rsp_hit       <= 1'b1;
            rsp_data      <= new_word;
            hit_count     <= hit_count + CNT_W'(1);
            state         <= S_IDLE;
            sb_st[b_e]    <= prefetch_en ? E_QUEUED : E_EMPTY;
            sb_line[b_e]  <= pf_next;
            if (prefetch_en) pf_next <= pf_next + LA_W'(1);
          end else if (!b_wait) begin
            state    <= S_DREQ;
            sb_st[0] <= E_EMPTY;
            sb_st[1] <= E_EMPTY;
            mem_drop <= (mem_busy && mem_own && !mem_rsp_valid) || pf_fire;
          end
        end
        S_DREQ: if (fire) state <= S_DWAIT;
        S_DWAIT: if (fill) begin
          rsp_valid  <= 1'b1;
          rsp_hit    <= 1'b0;
          rsp_data   <= new_word;
          miss_count <= miss_count + CNT_W'(1);
          state      <= S_IDLE;
          if (prefetch_en) begin
            sb_st[0]   <= E_QUEUED;
            sb_line[0] <= line_q + LA_W'(1);
            sb_st[1]   <= E_QUEUED;
            sb_line[1] <= line_q + LA_W'(2);
            pf_next    <= line_q + LA_W'(3);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  assert_demand_issued_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(state == S_DWAIT) |-> $past(mem_req_valid && mem_req_addr[31:OFF_W] == line_q));

  assert_miss_after_line_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_hit |-> $past(mem_rsp_valid));

  assert_hit_counted_R12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_hit |-> hit_count == $past(hit_count) + CNT_W'(1));

  assert_miss_counted_R12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_hit |-> miss_count == $past(miss_count) + CNT_W'(1));

  assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);
endmodule

// File: tb/stream_prefetch_cache_tb.sv
`timescale 1ns/1ps
module stream_prefetch_cache_tb;
  localparam int LW = 256;

  logic          clk = 1'b0, rst = 1'b1, prefetch_en = 1'b0;
  logic          req_valid = 1'b0, req_ready;
  logic [31:0]   req_addr = '0;
  logic          rsp_valid, rsp_hit;
  logic [31:0]   rsp_data;
  logic          mem_req_valid, mem_req_ready = 1'b1;
  logic [31:0]   mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [LW-1:0] mem_rsp_data = '0;
  logic [31:0]   hit_count, miss_count;

  stream_prefetch_cache u_dut (
    .clk(clk), .rst(rst), .prefetch_en(prefetch_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .hit_count(hit_count), .miss_count(miss_count));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, lat = 3, exp_hits = 0, exp_misses = 0;
  logic [31:0] q_data[$];
  logic        q_hit[$];
  string       q_tag[$];
  logic [31:0] req_log[$];

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return ((a & ~32'h3) * 32'h9E37_79B1) ^ 32'h1357_2468;
  endfunction

  function automatic logic [LW-1:0] line_at(input logic [31:0] la);
    logic [LW-1:0] r;
    for (int k = 0; k < 8; k++) r[k*32 +: 32] = word_at(la + 32'(4*k));
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // memory model: one request at a time, variable latency
  bit mbusy = 0;
  int mcnt = 0;
  logic [31:0] mladr = '0;
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (rst) mbusy = 0;
    else if (mbusy) begin
      if (mcnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = line_at(mladr);
        mbusy = 0;
      end else mcnt--;
    end else if (mem_req_valid === 1'b1) begin
      mbusy = 1;
      mladr = mem_req_addr;
      mcnt  = lat + (req_log.size() % 3);
      req_log.push_back(mem_req_addr);
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid === 1'b1) begin
      if (q_data.size() == 0) check(1'b0, "R4 unexpected response", rsp_data, 32'h0);
      else begin
        logic [31:0] d;
        logic h;
        string t;
        d = q_data.pop_front(); h = q_hit.pop_front(); t = q_tag.pop_front();
        check(rsp_data == d, {t, " data"}, rsp_data, d);
        check(rsp_hit == h, {t, " hit flag"}, 32'(rsp_hit), 32'(h));
      end
    end
  end

  task automatic access(input logic [31:0] a, input bit hit, input string tag);
    q_data.push_back(word_at(a)); q_hit.push_back(hit); q_tag.push_back(tag);
    if (hit) exp_hits++; else exp_misses++;
    req_addr  = a;
    req_valid = 1'b1;
    while (req_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (q_data.size() != 0) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_test();
  end

  initial begin
    int s;
    bit found;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check(req_ready === 1'b1, "R1 req_ready", 32'(req_ready), 32'h1);
    check(rsp_valid === 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'h0);
    check(mem_req_valid === 1'b0, "R1 mem_req_valid", 32'(mem_req_valid), 32'h0);
    check(hit_count == 0, "R1 hit_count", hit_count, 32'h0);
    check(miss_count == 0, "R1 miss_count", miss_count, 32'h0);

    // R11 prefetch off: one miss per 16 accesses
    req_log.delete();
    for (int i = 0; i < 64; i++) access(32'h1000 + 32'(2*i), (i % 16) != 0, "R11 stream no prefetch");
    idle(30);
    check(req_log.size() == 4, "R11 request count", 32'(req_log.size()), 32'd4);
    for (int k = 0; k < 4 && k < req_log.size(); k++)
      check(req_log[k] == 32'h1000 + 32'(32*k), "R4 line address", req_log[k], 32'h1000 + 32'(32*k));
    check(miss_count == 4, "R12 miss_count", miss_count, 32'd4);
    check(hit_count == 60, "R12 hit_count", hit_count, 32'd60);

    // R13 / R5 / R7 prefetch on
    prefetch_en = 1'b1;
    req_log.delete();
    for (int i = 0; i < 256; i++) access(32'h4_0000 + 32'(2*i), i != 0, "R13 stream prefetch");
    idle(40);
    check(req_log.size() == 18, "R7 request count", 32'(req_log.size()), 32'd18);
    for (int k = 0; k < 18 && k < req_log.size(); k++)
      check(req_log[k] == 32'h4_0000 + 32'(32*k), (k < 3) ? "R5 prefetch order" : "R7 refill order",
            req_log[k], 32'h4_0000 + 32'(32*k));

    // R2 conflict and word select, R3 hit with no request, R6 promotion
    access(32'h8_0040, 1'b0, "R2 first");
    access(32'h9_0040, 1'b0, "R2 conflict");
    access(32'h8_0040, 1'b0, "R2 evicted");
    access(32'h8_004C, 1'b1, "R2 word 3");
    idle(40);
    s = req_log.size();
    access(32'h8_0044, 1'b1, "R3 array hit");
    check(req_log.size() == s, "R3 no memory request", 32'(req_log.size()), 32'(s));
    access(32'h8_0060, 1'b1, "R6 buffer hit");
    idle(40);
    s = req_log.size();
    access(32'h8_0064, 1'b1, "R6 promoted line");
    check(req_log.size() == s, "R6 no memory request", 32'(req_log.size()), 32'(s));

    // R8 pending entry
    lat = 20;
    idle(60);
    access(32'h000C_0000, 1'b0, "R8 miss");
    access(32'h000C_0020, 1'b1, "R8 pending hit");
    access(32'h000C_0040, 1'b1, "R8 next hit");

    // R9 flush and discard
    idle(80);
    access(32'h0010_0000, 1'b0, "R9 miss A");
    access(32'h0020_0000, 1'b0, "R9 miss far");
    access(32'h0020_0020, 1'b1, "R9 restart hit");
    idle(100);
    found = 0;
    for (int k = 0; k + 1 < req_log.size(); k++)
      if (!found && req_log[k] == 32'h0020_0000) begin
        found = 1;
        check(req_log[k+1] == 32'h0020_0020, "R9 restart address", req_log[k+1], 32'h0020_0020);
      end
    check(found, "R10 demand issued", 32'(found), 32'h1);

    check(hit_count == 32'(exp_hits), "R12 final hits", hit_count, 32'(exp_hits));
    check(miss_count == 32'(exp_misses), "R12 final misses", miss_count, 32'(exp_misses));
    finish_test();
  end
endmodule